// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Hours Field

This block holds the current time and date as seven packed-BCD fields: seconds, minutes, hours, day of week, date, month and two-digit year. A one-cycle `tick_i` pulse, produced once per second by an external prescaler, advances the seconds field. Carries then ripple through minutes, hours and the calendar fields in the same clock cycle.

The hours field carries its own format flag in bit 7. In 12-hour format, bit 5 is the PM flag. In 24-hour format, bit 5 is the upper bit of the tens-of-hours digit, which is needed for 20 to 23. The date wraps at the length of the current month, and February follows a divisible-by-four leap rule on the BCD year.

A register front end loads any field through a field-select vector and a shared data byte. All seven fields are continuously visible for readback and for an external alarm comparator.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset, the fields read as follows: seconds 0x00, minutes 0x00, hours 0x00 (24-hour format), day of week 0x01, date 0x01, month 0x01, year 0x00.
- R2: Seconds and minutes count 00..59 in BCD. They change only on a tick or a carry. A seconds wrap from 59 to 00 increments minutes in the same cycle.
- R3: With hours bit 7 = 0 (24-hour), bits 5:0 count BCD 00..23. The step from 23 to 00 issues a day carry, and bit 7 is never altered by counting.
- R4: With hours bit 7 = 1 (12-hour), bits 4:0 hold BCD 01..12 and bit 5 is PM (1 = PM). The step 11→12 inverts bit 5, and the step 12→01 leaves bit 5 unchanged.
- R5: In 12-hour format, a day carry occurs only on the step from 11 PM to 12 AM (hours 0xB1 → 0x92).
- R6: The day of week advances on each day carry through 1..7 and wraps from 7 to 1.
- R7: On a day carry, the date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in all other months except 02. The wrap increments the month.
- R8: In month 02, the date wraps after 29 if the BCD year value is a multiple of 4 (00 included), and after 28 otherwise.
- R9: The month wraps from 12 to 01 and increments the year, and the year wraps from 99 to 00.
- R10: `wr_sel_i` bit 0 = seconds, 1 = minutes, 2 = hours, 3 = day of week, 4 = date, 5 = month, 6 = year. A selected field takes `wr_data_i` at the next edge, except that hours bit 6 is always stored as 0.
- R11: In any cycle with at least one `wr_sel_i` bit set, `tick_i` is ignored for every field.
- R12: A field that holds a value at or above its upper limit returns to its lower limit on its next increment and issues its carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle advance pulse, once per second |
| wr_sel_i | input | 7 | Field load select, one bit per field |
| wr_data_i | input | 8 | Load value, packed BCD |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with format flag and PM / tens bit |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
The bench builds the block with the default week length of seven days, which keeps every field at its natural width. Because the load port can place any field next to its limit, the bench reaches each rollover in a single tick. It sweeps all 100 year values through the end of February, every month end, a full 60-second minute and full 24-hour days in both hour formats. Expected values come from plain decimal arithmetic converted to BCD inside the bench.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DOW   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  typedef logic [FIELD_W-1:0] bcd_t;

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + bcd_t'(1);
  endfunction

  // 10t+u divisible by 4 <=> 2t+u divisible by 4
  function automatic logic bcd_leap(input bcd_t y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/bcd_wrap_cnt.sv
module bcd_wrap_cnt
  import bcd_cal_pkg::*;
#(
  parameter bcd_t RST_VAL = 8'h00,
  parameter bcd_t MIN_VAL = 8'h00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  input  bcd_t max_i,
  output bcd_t q_o,
  output logic wrap_o
);
  bcd_t q;
  logic at_top;

  assign at_top = (q >= max_i);
  assign wrap_o = inc_i & ~ld_i & at_top;
  assign q_o    = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= RST_VAL;
    else if (ld_i)  q <= ld_val_i;
    else if (inc_i) q <= at_top ? MIN_VAL : bcd_inc(q);
  end

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q == $past(ld_val_i)); // R10
  AST_WRAP_TO_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && q >= max_i) |=> q == MIN_VAL); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(q)); // R2
endmodule

// File: rtl/bcd_hour_cnt.sv
module bcd_hour_cnt
  import bcd_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  output bcd_t q_o,
  output logic day_o
);
  bcd_t       q, nxt;
  logic       day_c;
  logic [4:0] h12;
  logic [5:0] h24;

  assign h12 = q[4:0];
  assign h24 = q[5:0];

  always_comb begin
    nxt   = q;
    day_c = 1'b0;
    if (q[7]) begin
      if (h12 >= 5'h12) begin
        nxt = {2'b10, q[5], 5'h01};
      end else if (h12 == 5'h11) begin
        nxt   = {2'b10, ~q[5], 5'h12};
        day_c = q[5];
      end else begin
        nxt = {2'b10, q[5], (h12[3:0] == 4'd9) ? {h12[4] + 1'b1, 4'd0} : h12 + 5'd1};
      end
    end else begin
      if (h24 >= 6'h23) begin
        nxt   = 8'h00;
        day_c = 1'b1;
      end else begin
        nxt = {2'b00, (h24[3:0] == 4'd9) ? {h24[5:4] + 2'd1, 4'd0} : h24 + 6'd1};
      end
    end
  end

  assign day_o = inc_i & ~ld_i & day_c;
  assign q_o   = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= 8'h00;
    else if (ld_i)  q <= ld_val_i & 8'hBF;
    else if (inc_i) q <= nxt;
  end

  AST_H12_PM_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && q[7] && q[4:0] == 5'h11) |=> q[5] != $past(q[5])); // R4
  AST_H12_PM_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && q[7] && q[4:0] == 5'h12) |=> (q[5] == $past(q[5])) && (q[4:0] == 5'h01)); // R4
  AST_MODE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i) |=> q[7] == $past(q[7])); // R3
  AST_DAY_AT_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_o |=> (q == 8'h00) || (q == 8'h92)); // R5
endmodule

// File: rtl/bcd_month_len.sv
module bcd_month_len
  import bcd_cal_pkg::*;
(
  input  bcd_t month_i,
  input  bcd_t year_i,
  output bcd_t last_o
);
  always_comb begin
    unique case (month_i)
      8'h02:                      last_o = bcd_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import bcd_cal_pkg::*;
#(
  parameter int unsigned DAYS_PER_WEEK = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [NUM_FIELDS-1:0] wr_sel_i,
  input  logic [FIELD_W-1:0]    wr_data_i,
  output logic [FIELD_W-1:0]    sec_o,
  output logic [FIELD_W-1:0]    min_o,
  output logic [FIELD_W-1:0]    hour_o,
  output logic [FIELD_W-1:0]    dow_o,
  output logic [FIELD_W-1:0]    date_o,
  output logic [FIELD_W-1:0]    month_o,
  output logic [FIELD_W-1:0]    year_o
);
  localparam bcd_t DOW_MAX = bcd_t'(DAYS_PER_WEEK);

  logic adv, sec_wrap, min_wrap, day_carry, date_wrap, month_wrap;
  logic dow_wrap_unused, year_wrap_unused;
  bcd_t date_last;

  // any write suppresses the tick
  assign adv = tick_i & ~(|wr_sel_i);

  bcd_wrap_cnt #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(adv), .ld_i(wr_sel_i[F_SEC]), .ld_val_i(wr_data_i),
    .max_i(8'h59), .q_o(sec_o), .wrap_o(sec_wrap));

  bcd_wrap_cnt #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_wrap), .ld_i(wr_sel_i[F_MIN]), .ld_val_i(wr_data_i),
    .max_i(8'h59), .q_o(min_o), .wrap_o(min_wrap));

  bcd_hour_cnt u_hour (
    .clk_i, .rst_ni, .inc_i(min_wrap), .ld_i(wr_sel_i[F_HOUR]), .ld_val_i(wr_data_i),
    .q_o(hour_o), .day_o(day_carry));

  bcd_wrap_cnt #(.RST_VAL(8'h01), .MIN_VAL(8'h01)) u_dow (
    .clk_i, .rst_ni, .inc_i(day_carry), .ld_i(wr_sel_i[F_DOW]), .ld_val_i(wr_data_i),
    .max_i(DOW_MAX), .q_o(dow_o), .wrap_o(dow_wrap_unused));

  bcd_month_len u_mlen (.month_i(month_o), .year_i(year_o), .last_o(date_last));

  bcd_wrap_cnt #(.RST_VAL(8'h01), .MIN_VAL(8'h01)) u_date (
    .clk_i, .rst_ni, .inc_i(day_carry), .ld_i(wr_sel_i[F_DATE]), .ld_val_i(wr_data_i),
    .max_i(date_last), .q_o(date_o), .wrap_o(date_wrap));

  bcd_wrap_cnt #(.RST_VAL(8'h01), .MIN_VAL(8'h01)) u_month (
    .clk_i, .rst_ni, .inc_i(date_wrap), .ld_i(wr_sel_i[F_MONTH]), .ld_val_i(wr_data_i),
    .max_i(8'h12), .q_o(month_o), .wrap_o(month_wrap));

  bcd_wrap_cnt #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_year (
    .clk_i, .rst_ni, .inc_i(month_wrap), .ld_i(wr_sel_i[F_YEAR]), .ld_val_i(wr_data_i),
    .max_i(8'h99), .q_o(year_o), .wrap_o(year_wrap_unused));

  AST_WRITE_BLOCKS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|wr_sel_i) && !wr_sel_i[F_SEC]) |=> sec_o == $past(sec_o)); // R11
  AST_MIN_ON_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && sec_o == 8'h59 && min_o == 8'h00) |=> min_o == 8'h01); // R2
  AST_DATE_WRAP_MONTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_carry && date_o == date_last && month_o != 8'h12) |=> (date_o == 8'h01) && (month_o != $past(month_o))); // R7
  AST_DOW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_carry && dow_o == DOW_MAX) |=> dow_o == 8'h01); // R6
endmodule

// File: tb/bcd_clock_calendar_bench.sv
module bcd_clock_calendar_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec, mnt, hour, dow, date, month, year;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  bcd_clock_calendar u_bcd_clock_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(mnt), .hour_o(hour), .dow_o(dow), .date_o(date),
    .month_o(month), .year_o(year));

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int f, input logic [7:0] v);
    @(negedge clk);
    wr_sel = 7'(1 << f);
    wr_data = v;
    @(negedge clk);
    wr_sel = '0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic to_midnight(input logic [7:0] h);
    wr(2, h);
    wr(1, 8'h59);
    wr(0, 8'h59);
    tk();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sec", sec, 8'h00);    chk("R1 min", mnt, 8'h00);
    chk("R1 hour", hour, 8'h00);  chk("R1 dow", dow, 8'h01);
    chk("R1 date", date, 8'h01);  chk("R1 month", month, 8'h01);
    chk("R1 year", year, 8'h00);

    // R2 full minute of seconds
    for (int i = 1; i <= 60; i++) begin
      tk();
      chk("R2 sec", sec, to_bcd(i % 60));
    end
    chk("R2 min carry", mnt, 8'h01);
    repeat (5) @(negedge clk);
    chk("R2 hold", sec, 8'h00);

    // R3 24-hour day, R6 dow wrap
    wr(3, 8'h07); wr(4, 8'h10); wr(5, 8'h01);
    wr(2, 8'h00);
    for (int i = 0; i < 24; i++) begin
      wr(1, 8'h59); wr(0, 8'h59); tk();
      chk("R3 hour24", hour, to_bcd((i + 1) % 24));
      if (i == 22) chk("R3 no early carry", date, 8'h10);
    end
    chk("R3 date carry", date, 8'h11);
    chk("R6 dow 7 to 1", dow, 8'h01);

    // R4/R5 12-hour day from 12 AM
    wr(3, 8'h03); wr(4, 8'h05);
    wr(2, 8'h92);
    for (int i = 0; i < 24; i++) begin
      int n, h;
      wr(1, 8'h59); wr(0, 8'h59); tk();
      n = (i + 1) % 24;
      h = (n % 12 == 0) ? 12 : n % 12;
      chk("R4 hour12", hour, 8'h80 | ((n >= 12) ? 8'h20 : 8'h00) | to_bcd(h));
      if (i == 22) chk("R5 no carry before 11PM wrap", date, 8'h05);
    end
    chk("R5 date carry", date, 8'h06);
    chk("R6 dow step", dow, 8'h04);

    // R7 month ends, non-leap year
    for (int m = 1; m <= 12; m++) begin
      int d;
      d = mdays(m, 23);
      wr(6, 8'h23); wr(5, to_bcd(m)); wr(4, to_bcd(d - 1));
      to_midnight(8'h23);
      chk("R7 no wrap before end", date, to_bcd(d));
      to_midnight(8'h23);
      chk("R7 date wrap", date, 8'h01);
      chk("R7 month step", month, to_bcd((m % 12) + 1));
      chk("R9 year", year, (m == 12) ? 8'h24 : 8'h23);
    end

    // R8 February over all years
    for (int y = 0; y < 100; y++) begin
      wr(6, to_bcd(y)); wr(5, 8'h02); wr(4, 8'h28);
      to_midnight(8'h23);
      chk("R8 feb end", date, (y % 4 == 0) ? 8'h29 : 8'h01);
    end

    // R9 year wrap
    wr(6, 8'h99); wr(5, 8'h12); wr(4, 8'h31);
    to_midnight(8'hB1);
    chk("R9 year wrap", year, 8'h00);
    chk("R9 month wrap", month, 8'h01);
    chk("R5 12h midnight", hour, 8'h92);

    // R10 load and bit 6 masking
    wr(2, 8'h45);  chk("R10 hour bit6", hour, 8'h05);
    wr(2, 8'hC7);  chk("R10 hour bit6 12h", hour, 8'h87);
    wr(3, 8'h05);  chk("R10 dow", dow, 8'h05);

    // R11 write blocks tick
    wr(0, 8'h10);
    @(negedge clk);
    wr_sel = 7'b0000010; wr_data = 8'h33; tick = 1'b1;
    @(negedge clk);
    wr_sel = '0; tick = 1'b0;
    chk("R11 sec unchanged", sec, 8'h10);
    chk("R11 min loaded", mnt, 8'h33);

    // R12 out-of-range values
    wr(1, 8'h10); wr(0, 8'h75); tk();
    chk("R12 sec wrap", sec, 8'h00);
    chk("R12 min carry", mnt, 8'h11);
    wr(6, 8'h23); wr(5, 8'h02); wr(4, 8'h31);
    to_midnight(8'h23);
    chk("R12 date wrap", date, 8'h01);
    chk("R12 month carry", month, 8'h03);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule